// File: doc/BRIEF.md
# Local Interrupt Controller Register File

This block holds the software-visible configuration registers of a local interrupt controller. It sits behind a simple 32-bit word-addressed bus. Each register applies its own write rule:

- Some registers store only part of the written word.
- One register forces a fixed pattern into its low bits.
- One register cannot be written at all.
- The local vector table entries protect two status bits from software.

Reads are combinational from the stored state, so `bus_rdata` is valid in the same cycle as the address. Write effects and read side effects take hold at the next rising clock edge.

The error status register collects sticky error bits from the `err_src` input, and software clears it with a two-write sequence. An internal armed flag records the first write. The second write, while the flag is still set, zeroes the register. Any read of the register drops the flag, so a read placed between the two writes restarts the sequence. The software-enable flag follows bit 8 of the last value written to the spurious vector register and is driven out on `sw_enable`.

Top module: `irq_regfile`

Word addresses:

| Address | Register |
|---|---|
| 0 | identifier |
| 1 | version |
| 2 | task priority |
| 3 | logical destination |
| 4 | destination format |
| 5 | spurious vector |
| 6 | error status |
| 8 .. 8+NUM_VEC-1 | vector table entries |

All other addresses are unimplemented.

## Requirements
- R1: A write to the identifier register (address 0) or the task priority register (address 2) stores bits 7:0 of the data. Bits 31:8 read back as zero.
- R2: The version register (address 1) always reads VERSION_VAL. Writes to it change nothing.
- R3: A write to the logical destination register (address 3) keeps data bits 31:24. Bits 23:0 read back as zero.
- R4: A write to the destination format register (address 4) stores data bits 31:28. Bits 27:0 read back as all ones after any write.
- R5: A write to a vector table entry (address 8+i) updates every bit except bits 12 and 14. Those two bits keep their previous values.
- R6: A write to the spurious vector register (address 5) stores the whole word and sets `sw_enable` to data bit 8 from the next cycle.
- R7: A write to error status (address 6) while the armed flag is clear sets the flag and leaves the register contents unchanged. A write while the flag is set clears the flag and zeroes the register.
- R8: Any read of error status clears the armed flag, so a later write only re-arms the flag.
- R9: Each bit set on `err_src` in a cycle sets the matching error status bit (bits ERR_W-1:0) from the next cycle. The bit stays set until the two-write clear. A source bit that is active during the clearing write survives that write.
- R10: After reset, every vector table entry reads 32'h0001_0000 (mask bit 16 set). Every other implemented register reads zero except version, and `sw_enable` is 0.
- R11: Reads of unimplemented addresses (7 and 8+NUM_VEC upward) return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 4 | Word address of the access |
| bus_wr | input | 1 | Write strobe, takes effect at the next rising edge |
| bus_rd | input | 1 | Read strobe. It only triggers read side effects and is ignored when bus_wr is also high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| err_src | input | ERR_W | Error source pulses, one bit per error kind |
| sw_enable | output | 1 | Software-enable flag from spurious vector bit 8 |

## Verification
The bench uses the defaults NUM_VEC=6 and ERR_W=8, with VERSION_VAL overridden to a non-default pattern. This shows that the version readback comes from the parameter and not from a constant. Six vector entries put the first unimplemented address above the table (14) within reach, next to the gap at address 7. An 8-bit error field lets the tests place separate sticky bits at both of its ends. The error-status tests cover the plain two-write clear, a read placed between the two writes, and a source pulse that coincides with the clearing write.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;

  localparam logic [AW-1:0] A_ID    = 4'd0;
  localparam logic [AW-1:0] A_VER   = 4'd1;
  localparam logic [AW-1:0] A_TPRI  = 4'd2;
  localparam logic [AW-1:0] A_LDST  = 4'd3;
  localparam logic [AW-1:0] A_DFMT  = 4'd4;
  localparam logic [AW-1:0] A_SPUR  = 4'd5;
  localparam logic [AW-1:0] A_ESTAT = 4'd6;
  localparam logic [AW-1:0] A_LVT0  = 4'd8;

  localparam logic [DW-1:0] LVT_RO_MASK = 32'h0000_5000;
  localparam logic [DW-1:0] LVT_RST     = 32'h0001_0000;
  localparam logic [DW-1:0] DFMT_FORCE  = 32'h0FFF_FFFF;
  localparam logic [DW-1:0] LDST_KEEP   = 32'hFF00_0000;
  localparam int unsigned   SWEN_BIT    = 8;

  function automatic logic [DW-1:0] keep_low_byte(input logic [DW-1:0] d);
    return {24'h0, d[7:0]};
  endfunction

  function automatic logic [DW-1:0] ldst_filter(input logic [DW-1:0] d);
    return d & LDST_KEEP;
  endfunction

  function automatic logic [DW-1:0] dfmt_filter(input logic [DW-1:0] d);
    return d | DFMT_FORCE;
  endfunction

  function automatic logic [DW-1:0] lvt_merge(input logic [DW-1:0] old_v,
                                              input logic [DW-1:0] d);
    return (d & ~LVT_RO_MASK) | (old_v & LVT_RO_MASK);
  endfunction

endpackage

// File: rtl/irq_lvt_bank.sv
module irq_lvt_bank
  import irq_regs_pkg::*;
#(
  parameter int unsigned NUM_VEC = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_VEC-1:0]           wr_sel,
  input  logic [DW-1:0]                wdata,
  output logic [NUM_VEC-1:0][DW-1:0]   entry_q
);

  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        entry_q[gi] <= LVT_RST;
      end else if (wr_sel[gi]) begin
        entry_q[gi] <= lvt_merge(entry_q[gi], wdata);
      end
    end
  end

endmodule

// File: rtl/irq_err_status.sv
module irq_err_status #(
  parameter int unsigned ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             rd_hit,
  input  logic [ERR_W-1:0] src,
  output logic [ERR_W-1:0] bits_q,
  output logic             armed_q,
  output logic             arm_evt,
  output logic             clr_evt
);

  assign arm_evt = wr_hit && !armed_q;
  assign clr_evt = wr_hit && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      if (clr_evt) begin
        bits_q  <= src;
        armed_q <= 1'b0;
      end else begin
        bits_q <= bits_q | src;
        if (arm_evt) begin
          armed_q <= 1'b1;
        end else if (rd_hit) begin
          armed_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_regs_pkg::*;
#(
  parameter int unsigned   NUM_VEC     = 6,
  parameter int unsigned   ERR_W       = 8,
  parameter logic [31:0]   VERSION_VAL = 32'h0005_0014
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [ERR_W-1:0] err_src,
  output logic             sw_enable
);

  localparam int unsigned LVT_LAST = int'(A_LVT0) + NUM_VEC - 1;

  logic [DW-1:0] id_q, tpri_q, ldst_q, dfmt_q, spur_q;
  logic          swen_q;
  logic          rd_eff;

  logic [NUM_VEC-1:0]         lvt_hit;
  logic [NUM_VEC-1:0]         lvt_wr_evt;
  logic [NUM_VEC-1:0][DW-1:0] lvt_q;
  logic [2*NUM_VEC-1:0]       lvt_ro_flat;

  logic             spur_wr_evt;
  logic             estat_wr, estat_rd;
  logic [ERR_W-1:0] estat_bits;
  logic             estat_armed;
  logic             estat_arm_evt, estat_clr_evt;

  assign rd_eff      = bus_rd && !bus_wr;
  assign spur_wr_evt = bus_wr && (bus_addr == A_SPUR);
  assign estat_wr    = bus_wr && (bus_addr == A_ESTAT);
  assign estat_rd    = rd_eff && (bus_addr == A_ESTAT);

  for (genvar gi = 0; gi < NUM_VEC; gi++) begin : g_dec
    assign lvt_hit[gi]            = (bus_addr == AW'(int'(A_LVT0) + gi));
    assign lvt_wr_evt[gi]         = bus_wr && lvt_hit[gi];
    assign lvt_ro_flat[2*gi]      = lvt_q[gi][12];
    assign lvt_ro_flat[2*gi+1]    = lvt_q[gi][14];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      tpri_q <= '0;
      ldst_q <= '0;
      dfmt_q <= '0;
      spur_q <= '0;
      swen_q <= 1'b0;
    end else if (bus_wr) begin
      unique case (bus_addr)
        A_ID:    id_q   <= keep_low_byte(bus_wdata);
        A_TPRI:  tpri_q <= keep_low_byte(bus_wdata);
        A_LDST:  ldst_q <= ldst_filter(bus_wdata);
        A_DFMT:  dfmt_q <= dfmt_filter(bus_wdata);
        A_SPUR: begin
          spur_q <= bus_wdata;
          swen_q <= bus_wdata[SWEN_BIT];
        end
        default: ;
      endcase
    end
  end

  irq_lvt_bank #(.NUM_VEC(NUM_VEC)) u_lvt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_sel  (lvt_wr_evt),
    .wdata   (bus_wdata),
    .entry_q (lvt_q)
  );

  irq_err_status #(.ERR_W(ERR_W)) u_estat (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_hit  (estat_wr),
    .rd_hit  (estat_rd),
    .src     (err_src),
    .bits_q  (estat_bits),
    .armed_q (estat_armed),
    .arm_evt (estat_arm_evt),
    .clr_evt (estat_clr_evt)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_ID:    bus_rdata = id_q;
      A_VER:   bus_rdata = VERSION_VAL;
      A_TPRI:  bus_rdata = tpri_q;
      A_LDST:  bus_rdata = ldst_q;
      A_DFMT:  bus_rdata = dfmt_q;
      A_SPUR:  bus_rdata = spur_q;
      A_ESTAT: bus_rdata = DW'(estat_bits);
      default: begin
        for (int i = 0; i < NUM_VEC; i++) begin
          if (lvt_hit[i]) bus_rdata = lvt_q[i];
        end
      end
    endcase
  end

  assign sw_enable = swen_q;

endmodule

// File: rtl/irq_regfile_chk.sv
module irq_regfile_chk #(
  parameter int unsigned NUM_VEC     = 6,
  parameter int unsigned ERR_W       = 8,
  parameter logic [31:0] VERSION_VAL = 32'h0005_0014
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [3:0]           bus_addr,
  input logic                 bus_wr,
  input logic                 bus_rd,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [ERR_W-1:0]     err_src,
  input logic                 sw_enable,
  input logic [ERR_W-1:0]     estat_bits,
  input logic                 estat_armed,
  input logic [2*NUM_VEC-1:0] lvt_ro_flat
);

  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'd0 || bus_addr == 4'd2) |-> (bus_rdata[31:8] == 24'h0)); // R1

  AST_VERSION_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'd1) |-> (bus_rdata == VERSION_VAL)); // R2

  AST_DFMT_LOW_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd4) |=> (bus_addr != 4'd4 || bus_rdata[27:0] == 28'hFFF_FFFF)); // R4

  AST_LVT_RO_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(lvt_ro_flat)); // R5

  AST_SWEN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd5) |=> (sw_enable == $past(bus_wdata[8]))); // R6

  AST_ESTAT_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd6 && !estat_armed) |=>
      (estat_armed && estat_bits == ($past(estat_bits) | $past(err_src)))); // R7

  AST_ESTAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 4'd6 && estat_armed) |=>
      (!estat_armed && estat_bits == $past(err_src))); // R7

  AST_ESTAT_RD_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 4'd6) |=> !estat_armed); // R8

  AST_ESTAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_src != '0) |=> ((estat_bits & $past(err_src)) == $past(err_src))); // R9

  AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 4'd7 || int'(bus_addr) >= 8 + NUM_VEC) |-> (bus_rdata == 32'h0)); // R11

endmodule

bind irq_regfile irq_regfile_chk #(
  .NUM_VEC(NUM_VEC), .ERR_W(ERR_W), .VERSION_VAL(VERSION_VAL)
) u_chk (.*);

// File: tb/test_irq_regfile.sv
`timescale 1ns/1ps
module test_irq_regfile;

  localparam int unsigned NV  = 6;
  localparam int unsigned EW  = 8;
  localparam logic [31:0] VER = 32'h00AB_0012;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [EW-1:0] err_src = '0;
  logic          sw_enable;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  irq_regfile #(.NUM_VEC(NV), .ERR_W(EW), .VERSION_VAL(VER)) i_irq_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .err_src(err_src), .sw_enable(sw_enable)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_err(input logic [EW-1:0] s);
    @(negedge clk);
    err_src = s;
    @(negedge clk);
    err_src = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(4'd0, v); chk("R10 id reset", v, 32'h0);
    rd(4'd1, v); chk("R10 version reset", v, VER);
    rd(4'd4, v); chk("R10 dfmt reset", v, 32'h0);
    rd(4'd6, v); chk("R10 estat reset", v, 32'h0);
    for (int i = 0; i < NV; i++) begin
      rd(4'(8 + i), v); chk("R10 lvt reset", v, 32'h0001_0000);
    end
    chk("R10 sw_enable reset", {31'h0, sw_enable}, 32'h0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    wr(4'd0, 32'hDEAD_BEEF); rd(4'd0, v); chk("R1 id", v, 32'h0000_00EF);
    wr(4'd2, 32'h1234_5678); rd(4'd2, v); chk("R1 tpri", v, 32'h0000_0078);
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1, v); chk("R2 version", v, VER);
    wr(4'd3, 32'hABCD_EF12); rd(4'd3, v); chk("R3 ldst", v, 32'hAB00_0000);
    wr(4'd4, 32'h3000_0000); rd(4'd4, v); chk("R4 dfmt", v, 32'h3FFF_FFFF);
    wr(4'd4, 32'h8000_0001); rd(4'd4, v); chk("R4 dfmt2", v, 32'h8FFF_FFFF);
  endtask

  task automatic t_lvt();
    logic [31:0] v;
    wr(4'd8, 32'hFFFF_FFFF); rd(4'd8, v); chk("R5 lvt ones", v, 32'hFFFF_AFFF);
    wr(4'd8, 32'h0000_0000); rd(4'd8, v); chk("R5 lvt zero", v, 32'h0);
    wr(4'd13, 32'h0000_50A5); rd(4'd13, v); chk("R5 lvt last", v, 32'h0000_00A5);
    rd(4'd9, v); chk("R5 lvt neighbour", v, 32'h0001_0000);
  endtask

  task automatic t_spur();
    logic [31:0] v;
    wr(4'd5, 32'h0000_01FF); rd(4'd5, v); chk("R6 spur value", v, 32'h0000_01FF);
    chk("R6 swen set", {31'h0, sw_enable}, 32'h1);
    wr(4'd5, 32'hFFFF_FEFF);
    chk("R6 swen clear", {31'h0, sw_enable}, 32'h0);
  endtask

  task automatic t_estat();
    logic [31:0] v;
    pulse_err(8'h01); pulse_err(8'h80);
    rd(4'd6, v); chk("R9 sticky", v, 32'h81);
    wr(4'd6, 32'hFFFF_FFFF); rd(4'd6, v); chk("R7 first write keeps", v, 32'h81);
    wr(4'd6, 32'h0); rd(4'd6, v); chk("R8 read disarmed", v, 32'h81);
    wr(4'd6, 32'h0); wr(4'd6, 32'h0); rd(4'd6, v); chk("R7 two writes clear", v, 32'h0);
    pulse_err(8'h30);
    wr(4'd6, 32'h0);
    @(negedge clk);
    bus_addr = 4'd6; bus_wdata = 32'h0; bus_wr = 1'b1; err_src = 8'h02;
    @(negedge clk);
    bus_wr = 1'b0; err_src = '0;
    rd(4'd6, v); chk("R9 source during clear", v, 32'h02);
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    wr(4'd7, 32'hFFFF_FFFF); rd(4'd7, v); chk("R11 addr7", v, 32'h0);
    wr(4'd14, 32'hFFFF_FFFF); rd(4'd14, v); chk("R11 addr14", v, 32'h0);
    rd(4'd15, v); chk("R11 addr15", v, 32'h0);
    rd(4'd0, v); chk("R11 id untouched", v, 32'h0000_00EF);
    rd(4'd13, v); chk("R11 lvt untouched", v, 32'h0000_00A5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    t_lvt();
    t_spur();
    t_estat();
    t_unimpl();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule